// File: doc/BRIEF.md
# Byte-Serial Column Mixer

This block computes the AES column-mixing step while keeping an 8-bit stream on both sides. Bytes arrive one per cycle, four to a column, row 0 first. A gathering register collects the first three bytes. When the fourth byte arrives, four GF(2^8) row multipliers produce the whole mixed column at once. The result then travels down a short alignment pipeline. A serializing register sends it out one byte per cycle, in row order.

A bypass control lets the last cipher round pass bytes through unchanged. Bypassed bytes keep the same latency as mixed ones, so the round schedule downstream stays identical. Every byte leaves exactly ten cycles after it was accepted. Columns may follow each other with no idle cycle and come out just as densely.

Top module: `byte_mixcol_top`

## Requirements
- R1: While `rst` is high, and after its release until ten cycles after the first accepted byte, `outValid` is low.
- R2: For a column s0..s3 (s0 entered first), mixed output row r equals {02}·s[r] ⊕ {03}·s[(r+1) mod 4] ⊕ s[(r+2) mod 4] ⊕ s[(r+3) mod 4]; the column db,13,53,45 gives 8e,4d,a1,bc.
- R3: Multiplying by {02} shifts the byte left by one bit and XORs 0x1B when the original bit 7 was set; operands with bit 7 set (such as 0x80 and 0xff) reduce correctly.
- R4: A byte accepted with `inValid` high at clock edge n appears on `outByte`, with `outValid` high, in the cycle following edge n+10.
- R5: Each column produces `outValid` high for exactly four consecutive cycles, carrying rows 0, 1, 2, 3 in that order.
- R6: Columns entered back to back, with no idle cycle, leave back to back, with no idle cycle between their outputs.
- R7: When `bypass` is high, each output byte equals the corresponding input byte, with the same latency as in R4.
- R8: `bypass` is sampled only in the cycle in which the fourth byte of a column is accepted; its value in the other cycles has no effect.
- R9: A column is accepted as four consecutive `inValid` cycles. Idle gaps of any length between columns are allowed and do not disturb the row grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is present this cycle |
| inByte | input | 8 | Input byte; rows of a column arrive in order 0..3 |
| bypass | input | 1 | Pass the column through unmixed; sampled with its fourth byte |
| outValid | output | 1 | Output byte is present this cycle |
| outByte | output | 8 | Output byte, rows in order 0..3 |

## Verification
Every result is due exactly ten edges after its input byte was sampled, whether the column is mixed or bypassed. The bench therefore files each expected byte under the cycle index of its sampling edge plus ten. It compares `outValid` and `outByte` at the falling edge of every cycle, so an idle cycle is checked as strictly as a busy one. A column's expected values are fixed only when its fourth byte is driven, because that is the cycle whose `bypass` value counts. Bypass toggles on the other bytes of the column then show up as mismatches at their due cycles.

// File: rtl/byte_mixcol_pkg.sv
package byte_mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1b;

  typedef logic [ROWS-1:0][BYTE_W-1:0] column_t;

  typedef struct packed {
    logic shiftIn;   // accept a byte into the gather register
    logic colDone;   // fourth byte present: compute column
    logic loadOut;   // move aligned column into serializer
    logic shiftOut;  // advance serializer by one byte
  } ctlStrobes_t;

  function automatic logic [BYTE_W-1:0] gfDouble(input logic [BYTE_W-1:0] b);
    gfDouble = {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? REDUCE_POLY : '0);
  endfunction
endpackage

// File: rtl/byte_mixcol_ctrl.sv
module byte_mixcol_ctrl
  import byte_mixcol_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctlStrobes_t strobes,
  output logic        outValid
);
  localparam int CNT_W  = $clog2(ROWS);
  localparam int STAGES = LATENCY - 3;

  logic [CNT_W-1:0]  rowCnt;
  logic [CNT_W-1:0]  remain;
  logic [STAGES-1:0] vPipe;
  logic              colDone;

  assign colDone = inValid && (rowCnt == CNT_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rowCnt <= '0;
    end else if (inValid) begin
      rowCnt <= colDone ? '0 : rowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[STAGES-2:0], colDone};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      outValid <= 1'b0;
    end else if (vPipe[STAGES-1]) begin
      remain   <= CNT_W'(ROWS - 1);
      outValid <= 1'b1;
    end else if (remain != '0) begin
      remain   <= remain - 1'b1;
      outValid <= 1'b1;
    end else begin
      outValid <= 1'b0;
    end
  end

  always_comb begin
    strobes.shiftIn  = inValid;
    strobes.colDone  = colDone;
    strobes.loadOut  = vPipe[STAGES-1];
    strobes.shiftOut = !vPipe[STAGES-1] && (remain != '0);
  end
endmodule

// File: rtl/byte_mixcol_dp.sv
module byte_mixcol_dp
  import byte_mixcol_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              bypass,
  output logic [BYTE_W-1:0] outByte
);
  localparam int STAGES = LATENCY - 3;

  logic [BYTE_W-1:0] gather [ROWS-1];
  logic [BYTE_W-1:0] hold   [ROWS-1];
  column_t           colIn;
  column_t           mixed;
  column_t           pipe   [STAGES];

  always_ff @(posedge clk) begin
    if (strobes.shiftIn) begin
      for (int r = 0; r < ROWS - 2; r++) gather[r] <= gather[r+1];
      gather[ROWS-2] <= inByte;
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS - 1; r++) colIn[r] = gather[r];
    colIn[ROWS-1] = inByte;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int R1I = (r + 1) % ROWS;
    localparam int R2I = (r + 2) % ROWS;
    localparam int R3I = (r + 3) % ROWS;
    assign mixed[r] = gfDouble(colIn[r]) ^ gfDouble(colIn[R1I]) ^ colIn[R1I]
                    ^ colIn[R2I] ^ colIn[R3I];
  end

  always_ff @(posedge clk) begin
    if (strobes.colDone) pipe[0] <= bypass ? colIn : mixed;
    for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outByte <= '0;
    end else if (strobes.loadOut) begin
      outByte <= pipe[STAGES-1][0];
    end else if (strobes.shiftOut) begin
      outByte <= hold[0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadOut) begin
      for (int r = 0; r < ROWS - 1; r++) hold[r] <= pipe[STAGES-1][r+1];
    end else if (strobes.shiftOut) begin
      for (int r = 0; r < ROWS - 2; r++) hold[r] <= hold[r+1];
    end
  end
endmodule

// File: rtl/byte_mixcol_top.sv
module byte_mixcol_top
  import byte_mixcol_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       bypass,
  output logic       outValid,
  output logic [7:0] outByte
);
  ctlStrobes_t strobes;

  byte_mixcol_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  byte_mixcol_dp #(.LATENCY(LATENCY)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .inByte (inByte),
    .bypass (bypass),
    .outByte(outByte)
  );
endmodule

// File: rtl/byte_mixcol_chk.sv
module byte_mixcol_chk #(
  parameter int LATENCY = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [7:0] inByte,
  input logic       bypass,
  input logic       outValid,
  input logic [7:0] outByte
);
  logic       histV [LATENCY+1];
  logic [7:0] histB [LATENCY+1];
  int         bypRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= LATENCY; i++) begin
        histV[i] <= 1'b0;
        histB[i] <= '0;
      end
      bypRun <= 0;
    end else begin
      histV[0] <= inValid;
      histB[0] <= inByte;
      for (int i = 1; i <= LATENCY; i++) begin
        histV[i] <= histV[i-1];
        histB[i] <= histB[i-1];
      end
      bypRun <= bypass ? ((bypRun > LATENCY + 4) ? bypRun : bypRun + 1) : 0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (rst)
    outValid == histV[LATENCY]);

  assert_four_beat_run_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |=> outValid ##1 outValid ##1 outValid);

  assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && bypRun > LATENCY) |-> outByte == histB[LATENCY]);
endmodule

bind byte_mixcol_top byte_mixcol_chk #(.LATENCY(LATENCY)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inByte  (inByte),
  .bypass  (bypass),
  .outValid(outValid),
  .outByte (outByte)
);

// File: tb/byte_mixcol_top_tb.sv
module byte_mixcol_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 10;
  localparam int MAXC       = 4000;

  logic       clk = 1'b0;
  logic       rst;
  logic       inValid;
  logic [7:0] inByte;
  logic       bypass;
  logic       outValid;
  logic [7:0] outByte;

  byte_mixcol_top #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte),
    .bypass(bypass), .outValid(outValid), .outByte(outByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 0;
  bit    expV   [MAXC];
  logic [7:0] expB [MAXC];
  string expTag [MAXC];
  logic [7:0] colBuf [4];
  int    colDue [4];
  int    colPos = 0;
  int    lastDue [4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] mixRow(input int r, input logic [7:0] c [4]);
    return gmul(c[r], 8'h02) ^ gmul(c[(r+1)%4], 8'h03) ^ c[(r+2)%4] ^ c[(r+3)%4];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One cycle: compare outputs due now, then drive the next inputs.
  task automatic step(input bit v, input logic [7:0] b, input bit byp, input string tag);
    @(negedge clk);
    if (expV[cyc] || outValid)
      check(outValid == expV[cyc], "R4", "outValid", outValid, expV[cyc]);
    if (expV[cyc] && outValid)
      check(outByte == expB[cyc], expTag[cyc], "outByte", outByte, expB[cyc]);
    inValid = v;
    inByte  = b;
    bypass  = byp;
    if (v) begin
      colBuf[colPos] = b;
      colDue[colPos] = cyc + 1 + LAT;
      if (colPos == 3) begin
        for (int r = 0; r < 4; r++) begin
          expV[colDue[r]]   = 1'b1;
          expB[colDue[r]]   = byp ? colBuf[r] : mixRow(r, colBuf);
          expTag[colDue[r]] = byp ? "R7" : tag;
          lastDue[r] = colDue[r];
        end
        colPos = 0;
      end else begin
        colPos++;
      end
    end
  endtask

  task automatic sendCol(input logic [7:0] b0, b1, b2, b3, input bit byp, input string tag);
    step(1, b0, byp, tag);
    step(1, b1, byp, tag);
    step(1, b2, byp, tag);
    step(1, b3, byp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'(i * 37 + 5), i[0], "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      expV[i] = 0; expB[i] = 0; expTag[i] = "R2";
    end
    rst = 1; inValid = 0; inByte = 0; bypass = 0;
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rst = 0;

    // Reference arithmetic sanity, fixed known answers (R2, R3)
    colBuf = '{8'hdb, 8'h13, 8'h53, 8'h45};
    check({mixRow(0, colBuf), mixRow(1, colBuf), mixRow(2, colBuf), mixRow(3, colBuf)}
          == 32'h8e4da1bc, "R2", "model column", 0, 0);
    check(gmul(8'h80, 8'h02) == 8'h1b, "R3", "model xtime", gmul(8'h80, 8'h02), 8'h1b);
    colPos = 0;

    idle(3);
    // R1: quiet until first output; R2 known column with literal expectations
    sendCol(8'hdb, 8'h13, 8'h53, 8'h45, 0, "R2");
    expB[lastDue[0]] = 8'h8e; expB[lastDue[1]] = 8'h4d;
    expB[lastDue[2]] = 8'ha1; expB[lastDue[3]] = 8'hbc;
    idle(14);

    // R5, R6: back-to-back columns with known results
    sendCol(8'hf2, 8'h0a, 8'h22, 8'h5c, 0, "R6");
    expB[lastDue[0]] = 8'h9f; expB[lastDue[1]] = 8'hdc;
    expB[lastDue[2]] = 8'h58; expB[lastDue[3]] = 8'h9d;
    sendCol(8'h01, 8'h01, 8'h01, 8'h01, 0, "R5");
    sendCol(8'hd4, 8'hd4, 8'hd4, 8'hd5, 0, "R6");
    expB[lastDue[0]] = 8'hd5; expB[lastDue[1]] = 8'hd5;
    expB[lastDue[2]] = 8'hd7; expB[lastDue[3]] = 8'hd6;
    sendCol(8'h2d, 8'h26, 8'h31, 8'h4c, 0, "R6");

    // R3: bytes with bit 7 set
    sendCol(8'h80, 8'hff, 8'h80, 8'hff, 0, "R3");
    sendCol(8'hff, 8'hff, 8'hff, 8'hff, 0, "R3");
    idle(2);

    // R7: bypass columns, also back to back with mixed ones
    sendCol(8'h11, 8'h22, 8'h33, 8'h44, 1, "R7");
    sendCol(8'hdb, 8'h13, 8'h53, 8'h45, 1, "R7");
    sendCol(8'hdb, 8'h13, 8'h53, 8'h45, 0, "R2");
    sendCol(8'hc6, 8'hc6, 8'hc6, 8'hc6, 1, "R7");
    idle(5);

    // R8: bypass toggled on the first three bytes only; fourth decides
    step(1, 8'hdb, 1, "R8"); step(1, 8'h13, 1, "R8");
    step(1, 8'h53, 1, "R8"); step(1, 8'h45, 0, "R8");
    expB[lastDue[0]] = 8'h8e;
    step(1, 8'h0a, 0, "R8"); step(1, 8'hb0, 0, "R8");
    step(1, 8'hc3, 0, "R8"); step(1, 8'h7e, 1, "R8");
    idle(3);

    // R9: columns separated by gaps of various lengths
    for (int k = 0; k < 12; k++) begin
      sendCol(8'(k * 29 + 3), 8'(k * 71 + 9), 8'(k * 113 + 1), 8'(k * 5 + 200),
              k[1] & k[0], "R9");
      idle(k % 5);
    end
    idle(20);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule